// File: doc/BRIEF.md
# Twin-Clock Byte-Masked Synchronous RAM

This block is a true dual-port synchronous RAM. Each of its two ports has its own clock, its own synchronous active-low reset and a full set of controls. Either port can read or write any word in any cycle, and both ports may reach the same word at once. Every access is taken from the inputs at the rising edge of that port's clock. The upper byte lane is bits 15..8 and the lower byte lane is bits 7..0, and each lane is enabled separately.

A port is selected by two enables of opposite polarity, so the selection logic of several devices can be cascaded for depth expansion. An active-low write line picks a write or a read. An output enable gates the read lanes asynchronously. A static mode input per port picks one of two read latencies: flow-through, with data in the cycle after the address edge, or pipelined, with one more register. Pads are modelled as a data word plus one valid bit per byte lane. A lane that does not drive reads as zero.

The default depth is 1024 words (`ADDR_W` = 10), which keeps elaboration small. The full-size configuration sets `ADDR_W` = 15 to get 32768 words. The storage contents are not reset.

Top module: `twin_port_ram`

## Requirements
- R1: A write with both lanes enabled stores the whole 16-bit word. A later flow-through read of that address, the lowest and the highest address included, shows the word with `rvalid` = 2'b11 in the cycle after its address edge.
- R2: A write changes only the lanes whose active-low select is low: `hi_n` controls bits 15..8 and `lo_n` controls bits 7..0. The other lane keeps its stored value.
- R3: A read drives only the lanes whose select is low. `rvalid[1]` flags the upper lane and `rvalid[0]` flags the lower lane. A lane that does not drive reads as zero.
- R4: A port is selected only when `en_n` is 0 and `en` is 1. With any other combination the port does not write, and none of its lanes becomes valid.
- R5: With the port selected and both lane selects high, nothing is read or written.
- R6: Output enable is asynchronous. While `oe_n` is 1, both `rvalid` bits and `rdata` are 0 within the same cycle, and the lanes come back as soon as `oe_n` returns to 0.
- R7: With `pipe` = 1, read data and `rvalid` appear one cycle later than in flow-through mode. `pipe` stays constant after reset.
- R8: Both ports can read the same word in the same cycle, and each returns it at its own latency.
- R9: When one port writes a word at the same clock edge as the other port reads it, the read returns the data held before the write.
- R10: While a port's reset is low, the port's `rvalid` bits clear at the next edge, even if a read was requested at that edge.
- R11: A write cycle produces no valid read lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous active-low reset |
| pipe_a | input | 1 | Port A mode: 1 pipelined, 0 flow-through (static) |
| en_a_n | input | 1 | Port A active-low enable |
| en_a | input | 1 | Port A active-high enable |
| we_a_n | input | 1 | Port A: 0 write, 1 read |
| oe_a_n | input | 1 | Port A asynchronous active-low output enable |
| hi_a_n | input | 1 | Port A upper-lane select, active low |
| lo_a_n | input | 1 | Port A lower-lane select, active low |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | 2*BYTE_W | Port A write data |
| rdata_a | output | 2*BYTE_W | Port A read data, non-driving lanes zero |
| rvalid_a | output | 2 | Port A lane valid: bit 1 upper, bit 0 lower |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous active-low reset |
| pipe_b | input | 1 | Port B mode: 1 pipelined, 0 flow-through (static) |
| en_b_n | input | 1 | Port B active-low enable |
| en_b | input | 1 | Port B active-high enable |
| we_b_n | input | 1 | Port B: 0 write, 1 read |
| oe_b_n | input | 1 | Port B asynchronous active-low output enable |
| hi_b_n | input | 1 | Port B upper-lane select, active low |
| lo_b_n | input | 1 | Port B lower-lane select, active low |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | 2*BYTE_W | Port B write data |
| rdata_b | output | 2*BYTE_W | Port B read data, non-driving lanes zero |
| rvalid_b | output | 2 | Port B lane valid: bit 1 upper, bit 0 lower |

## Verification
The bench writes single lanes and then reads back the neighbouring lane. A design that ignored the lane mask would overwrite that lane, and one that used the wrong mask would corrupt it. It drives each wrong polarity of the enable pair, and both lane selects high, with write data that differs from the stored word. A design that decoded only one enable, or that treated "no lane" as "all lanes", would alter memory or raise valid bits. It places a read on one port and a write to the same word on the other port at the same edge, and checks that the read returns the old data; a design that forwarded write data across ports would return the new word. It also toggles the output enable in the middle of a cycle and drops the reset while a read is in flight, which catches an output enable that was registered and valid bits that survive the reset.

// File: rtl/tpr_pkg.sv
// Package tpr_pkg: shared constants, the decoded-access record and the
// select decoder used by every port of the twin-port RAM.
// Assumes exactly two ports and two byte lanes (upper = index 1).
package tpr_pkg;

    localparam int NUM_PORTS = 2;
    localparam int NUM_LANES = 2;

    // Decoded access of one port for one clock edge.
    typedef struct packed {
        logic                 selected;
        logic [NUM_LANES-1:0] wr_lanes;
        logic [NUM_LANES-1:0] rd_lanes;
    } port_access_t;

    // Turns raw enables, direction and lane selects into lane masks.
    function automatic port_access_t decode_access(
        input logic                 en_n,
        input logic                 en,
        input logic                 we_n,
        input logic [NUM_LANES-1:0] lane_n
    );
        port_access_t acc;
        acc.selected = ~en_n & en;
        acc.wr_lanes = (acc.selected && !we_n) ? ~lane_n : '0;
        acc.rd_lanes = (acc.selected &&  we_n) ? ~lane_n : '0;
        return acc;
    endfunction

endpackage

// File: rtl/tpr_port_decode.sv
// tpr_port_decode: combinational decode of one port's control pins into
// write-lane and read-lane masks. Assumes the pins are stable around the
// rising edge of the port clock; nothing is registered here.
module tpr_port_decode
    import tpr_pkg::*;
(
    input  logic                 en_n,
    input  logic                 en,
    input  logic                 we_n,
    input  logic                 hi_n,
    input  logic                 lo_n,
    output port_access_t         acc
);

    // Purpose: apply the shared decoder to this port's pins.
    always_comb begin
        acc = decode_access(en_n, en, we_n, {hi_n, lo_n});
    end

endmodule

// File: rtl/tpr_bank.sv
// tpr_bank: one single-writer storage bank of the XOR-coded dual-port
// array. Only its owning port writes it, per byte lane, at that port's
// clock edge. It offers one asynchronous read per port. The caller
// pre-codes the write word with the other bank's contents. Contents are
// not reset.
module tpr_bank
    import tpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8,
    localparam int DATA_W = NUM_LANES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                                 clk,
    input  logic [NUM_LANES-1:0]                 wr_lanes,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_word,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]     rd_addr,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]     rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: lane-masked write from the owning port.
    always_ff @(posedge clk) begin
        for (int l = 0; l < NUM_LANES; l++) begin
            if (wr_lanes[l]) begin
                mem[wr_addr][l*BYTE_W +: BYTE_W] <= wr_word[l*BYTE_W +: BYTE_W];
            end
        end
    end

    // Purpose: one asynchronous read tap per port.
    for (genvar r = 0; r < NUM_PORTS; r++) begin : g_tap
        assign rd_word[r] = mem[rd_addr[r]];
    end

endmodule

// File: rtl/tpr_read_stage.sv
// tpr_read_stage: read-output path of one port. Stage 1 captures the
// word and the lane mask at the address edge (flow-through view). Stage 2
// adds one register (pipelined view). The static pipe input picks the
// stage, and the output enable gates the chosen stage asynchronously.
// Lanes that do not drive read as zero.
module tpr_read_stage
    import tpr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = NUM_LANES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pipe,
    input  logic                 oe_n,
    input  logic [NUM_LANES-1:0] rd_lanes,
    input  logic [DATA_W-1:0]    word_in,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LANES-1:0] rvalid
);

    logic [NUM_LANES-1:0] s1_lanes, s2_lanes, sel_lanes;
    logic [DATA_W-1:0]    s1_word,  s2_word,  sel_word;

    // Purpose: stage-1 lane mask, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_lanes <= '0;
        else        s1_lanes <= rd_lanes;
    end

    // Purpose: stage-1 word, loaded only on a read.
    always_ff @(posedge clk) begin
        if (|rd_lanes) s1_word <= word_in;
    end

    // Purpose: stage-2 lane mask for the pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_lanes <= '0;
        else        s2_lanes <= s1_lanes;
    end

    // Purpose: stage-2 word for the pipelined mode.
    always_ff @(posedge clk) begin
        if (|s1_lanes) s2_word <= s1_word;
    end

    // Purpose: latency select and asynchronous output gating.
    always_comb begin
        sel_lanes = pipe ? s2_lanes : s1_lanes;
        sel_word  = pipe ? s2_word  : s1_word;
        rvalid    = oe_n ? '0 : sel_lanes;
    end

    // Purpose: zero every lane that is not driving.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign rdata[l*BYTE_W +: BYTE_W] = rvalid[l] ? sel_word[l*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/twin_port_ram.sv
// twin_port_ram: true dual-port synchronous RAM with independent port
// clocks, dual-polarity selects, byte-lane masking, an asynchronous output
// enable and a per-port flow-through or pipelined read latency.
// Storage is two single-writer banks. A word is bank0 ^ bank1, and a write
// stores data ^ (other bank) into the writer's own bank. A read at the
// same edge as a write to the same word returns the old data.
// Assumes: pipe_* static after reset; storage not reset.
module twin_port_ram
    import tpr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8,
    localparam int DATA_W = NUM_LANES * BYTE_W
) (
    input  logic                 clk_a,
    input  logic                 rst_a_n,
    input  logic                 pipe_a,
    input  logic                 en_a_n,
    input  logic                 en_a,
    input  logic                 we_a_n,
    input  logic                 oe_a_n,
    input  logic                 hi_a_n,
    input  logic                 lo_a_n,
    input  logic [ADDR_W-1:0]    addr_a,
    input  logic [DATA_W-1:0]    wdata_a,
    output logic [DATA_W-1:0]    rdata_a,
    output logic [NUM_LANES-1:0] rvalid_a,
    input  logic                 clk_b,
    input  logic                 rst_b_n,
    input  logic                 pipe_b,
    input  logic                 en_b_n,
    input  logic                 en_b,
    input  logic                 we_b_n,
    input  logic                 oe_b_n,
    input  logic                 hi_b_n,
    input  logic                 lo_b_n,
    input  logic [ADDR_W-1:0]    addr_b,
    input  logic [DATA_W-1:0]    wdata_b,
    output logic [DATA_W-1:0]    rdata_b,
    output logic [NUM_LANES-1:0] rvalid_b
);

    logic                                    p_clk   [NUM_PORTS];
    logic                                    p_rst_n [NUM_PORTS];
    logic                                    p_pipe  [NUM_PORTS];
    logic                                    p_en_n  [NUM_PORTS];
    logic                                    p_en    [NUM_PORTS];
    logic                                    p_we_n  [NUM_PORTS];
    logic                                    p_oe_n  [NUM_PORTS];
    logic                                    p_hi_n  [NUM_PORTS];
    logic                                    p_lo_n  [NUM_PORTS];
    logic [DATA_W-1:0]                       p_wdata [NUM_PORTS];
    logic [DATA_W-1:0]                       p_rdata [NUM_PORTS];
    logic [NUM_LANES-1:0]                    p_rvalid[NUM_PORTS];
    logic [NUM_PORTS-1:0][ADDR_W-1:0]        all_addr;
    port_access_t                            p_acc   [NUM_PORTS];
    logic [NUM_PORTS-1:0][DATA_W-1:0]        bank_rd [NUM_PORTS];
    logic [DATA_W-1:0]                       p_word  [NUM_PORTS];
    logic [DATA_W-1:0]                       p_coded [NUM_PORTS];

    // Purpose: gather port A pins into the per-port arrays.
    assign p_clk[0]   = clk_a;
    assign p_rst_n[0] = rst_a_n;
    assign p_pipe[0]  = pipe_a;
    assign p_en_n[0]  = en_a_n;
    assign p_en[0]    = en_a;
    assign p_we_n[0]  = we_a_n;
    assign p_oe_n[0]  = oe_a_n;
    assign p_hi_n[0]  = hi_a_n;
    assign p_lo_n[0]  = lo_a_n;
    assign p_wdata[0] = wdata_a;
    assign all_addr[0] = addr_a;

    // Purpose: gather port B pins into the per-port arrays.
    assign p_clk[1]   = clk_b;
    assign p_rst_n[1] = rst_b_n;
    assign p_pipe[1]  = pipe_b;
    assign p_en_n[1]  = en_b_n;
    assign p_en[1]    = en_b;
    assign p_we_n[1]  = we_b_n;
    assign p_oe_n[1]  = oe_b_n;
    assign p_hi_n[1]  = hi_b_n;
    assign p_lo_n[1]  = lo_b_n;
    assign p_wdata[1] = wdata_b;
    assign all_addr[1] = addr_b;

    // Purpose: drive the output pins from the per-port results.
    assign rdata_a  = p_rdata[0];
    assign rvalid_a = p_rvalid[0];
    assign rdata_b  = p_rdata[1];
    assign rvalid_b = p_rvalid[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int OTHER = NUM_PORTS - 1 - p;

        tpr_port_decode u_dec (
            .en_n (p_en_n[p]),
            .en   (p_en[p]),
            .we_n (p_we_n[p]),
            .hi_n (p_hi_n[p]),
            .lo_n (p_lo_n[p]),
            .acc  (p_acc[p])
        );

        // Purpose: recover the stored word and code this port's write data.
        assign p_word[p]  = bank_rd[0][p] ^ bank_rd[1][p];
        assign p_coded[p] = p_wdata[p] ^ bank_rd[OTHER][p];

        tpr_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
            .clk      (p_clk[p]),
            .wr_lanes (p_acc[p].wr_lanes),
            .wr_addr  (all_addr[p]),
            .wr_word  (p_coded[p]),
            .rd_addr  (all_addr),
            .rd_word  (bank_rd[p])
        );

        tpr_read_stage #(.BYTE_W(BYTE_W)) u_out (
            .clk      (p_clk[p]),
            .rst_n    (p_rst_n[p]),
            .pipe     (p_pipe[p]),
            .oe_n     (p_oe_n[p]),
            .rd_lanes (p_acc[p].rd_lanes),
            .word_in  (p_word[p]),
            .rdata    (p_rdata[p]),
            .rvalid   (p_rvalid[p])
        );
    end

endmodule

// File: rtl/tpr_checker.sv
// tpr_checker: port-level properties of twin_port_ram, bound to every
// instance. The expected lane masks are recomputed from the pins here.
module tpr_checker #(
    parameter int ADDR_W = 10,
    parameter int BYTE_W = 8,
    localparam int DATA_W = 2 * BYTE_W
) (
    input logic              clk_a, rst_a_n, pipe_a, en_a_n, en_a, we_a_n, oe_a_n, hi_a_n, lo_a_n,
    input logic [ADDR_W-1:0] addr_a,
    input logic [DATA_W-1:0] wdata_a, rdata_a,
    input logic [1:0]        rvalid_a,
    input logic              clk_b, rst_b_n, pipe_b, en_b_n, en_b, we_b_n, oe_b_n, hi_b_n, lo_b_n,
    input logic [ADDR_W-1:0] addr_b,
    input logic [DATA_W-1:0] wdata_b, rdata_b,
    input logic [1:0]        rvalid_b
);

    logic [1:0] want_a, want_b;
    assign want_a = (!en_a_n && en_a && we_a_n) ? {~hi_a_n, ~lo_a_n} : 2'b00;
    assign want_b = (!en_b_n && en_b && we_b_n) ? {~hi_b_n, ~lo_b_n} : 2'b00;

    // R1 R3 R4 R5 R11: flow-through lanes follow the request one edge later
    assert_flow_lanes_a_R1: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (!pipe_a && !oe_a_n && $past(rst_a_n)) |-> (rvalid_a == $past(want_a)));
    assert_flow_lanes_b_R1: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (!pipe_b && !oe_b_n && $past(rst_b_n)) |-> (rvalid_b == $past(want_b)));

    // R7: pipelined lanes follow the request two edges later
    assert_pipe_lanes_a_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (pipe_a && !oe_a_n && $past(rst_a_n) && $past(rst_a_n, 2)) |-> (rvalid_a == $past(want_a, 2)));
    assert_pipe_lanes_b_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (pipe_b && !oe_b_n && $past(rst_b_n) && $past(rst_b_n, 2)) |-> (rvalid_b == $past(want_b, 2)));

    // R7: mode pin static once out of reset
    assert_mode_static_a_R7: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        $past(rst_a_n) |-> $stable(pipe_a));
    assert_mode_static_b_R7: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        $past(rst_b_n) |-> $stable(pipe_b));

    // R6: output enable high silences all lanes
    assert_oe_float_a_R6: assert property (@(posedge clk_a) oe_a_n |-> (rvalid_a == 2'b00));
    assert_oe_float_b_R6: assert property (@(posedge clk_b) oe_b_n |-> (rvalid_b == 2'b00));

    // R3: a non-driving lane reads zero
    assert_idle_lane_zero_a_R3: assert property (@(posedge clk_a)
        ((rvalid_a[1] || rdata_a[DATA_W-1:BYTE_W] == '0) && (rvalid_a[0] || rdata_a[BYTE_W-1:0] == '0)));
    assert_idle_lane_zero_b_R3: assert property (@(posedge clk_b)
        ((rvalid_b[1] || rdata_b[DATA_W-1:BYTE_W] == '0) && (rvalid_b[0] || rdata_b[BYTE_W-1:0] == '0)));

    // R10: reset clears the valid lanes at the next edge
    assert_reset_quiet_a_R10: assert property (@(posedge clk_a) !rst_a_n |=> (rvalid_a == 2'b00));
    assert_reset_quiet_b_R10: assert property (@(posedge clk_b) !rst_b_n |=> (rvalid_b == 2'b00));

endmodule

bind twin_port_ram tpr_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .pipe_a(pipe_a), .en_a_n(en_a_n), .en_a(en_a),
    .we_a_n(we_a_n), .oe_a_n(oe_a_n), .hi_a_n(hi_a_n), .lo_a_n(lo_a_n),
    .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a), .rvalid_a(rvalid_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .pipe_b(pipe_b), .en_b_n(en_b_n), .en_b(en_b),
    .we_b_n(we_b_n), .oe_b_n(oe_b_n), .hi_b_n(hi_b_n), .lo_b_n(lo_b_n),
    .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b), .rvalid_b(rvalid_b)
);

// File: tb/twin_port_ram_test.sv
// Scoreboard bench: port A flow-through, port B pipelined, one shared clock.
module twin_port_ram_test;

    localparam int AW = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic en_a_n = 1, en_a = 0, we_a_n = 1, oe_a_n = 0, hi_a_n = 1, lo_a_n = 1;
    logic en_b_n = 1, en_b = 0, we_b_n = 1, oe_b_n = 0, hi_b_n = 1, lo_b_n = 1;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [15:0]   wdata_a = '0, wdata_b = '0, rdata_a, rdata_b;
    logic [1:0]    rvalid_a, rvalid_b;

    twin_port_ram #(.ADDR_W(AW), .BYTE_W(8)) uut (
        .clk_a(clk), .rst_a_n(rst_a_n), .pipe_a(1'b0), .en_a_n(en_a_n), .en_a(en_a),
        .we_a_n(we_a_n), .oe_a_n(oe_a_n), .hi_a_n(hi_a_n), .lo_a_n(lo_a_n),
        .addr_a(addr_a), .wdata_a(wdata_a), .rdata_a(rdata_a), .rvalid_a(rvalid_a),
        .clk_b(clk), .rst_b_n(rst_b_n), .pipe_b(1'b1), .en_b_n(en_b_n), .en_b(en_b),
        .we_b_n(we_b_n), .oe_b_n(oe_b_n), .hi_b_n(hi_b_n), .lo_b_n(lo_b_n),
        .addr_b(addr_b), .wdata_b(wdata_b), .rdata_b(rdata_b), .rvalid_b(rvalid_b)
    );

    typedef struct {
        int         port;
        int         due;
        logic [1:0] lanes;
        logic [15:0] data;
        string      tag;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] model [1 << AW];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual valid/data %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: compare due scoreboard items at the falling edge.
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
                logic [1:0]  v;
                logic [15:0] d, m;
                v = (sbq[i].port == 0) ? rvalid_a : rvalid_b;
                d = (sbq[i].port == 0) ? rdata_a  : rdata_b;
                m = {{8{sbq[i].lanes[1]}}, {8{sbq[i].lanes[0]}}};
                report((v == sbq[i].lanes) && (d == (sbq[i].data & m)), sbq[i].tag,
                       {v, d}, {sbq[i].lanes, sbq[i].data & m});
                sbq.delete(i);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Driver: set one port's pins for this cycle and push the expectation.
    task automatic access(input int p, input logic sel_n, input logic sel, input logic wr_n,
                          input logic h_n, input logic l_n, input logic [AW-1:0] a,
                          input logic [15:0] d, input string tag);
        exp_t e;
        logic ok;
        ok = !sel_n && sel;
        e.port = p;
        e.due  = cyc + ((p == 0) ? 1 : 2);
        e.tag  = tag;
        e.data = model[a];
        e.lanes = (ok && wr_n) ? {~h_n, ~l_n} : 2'b00;
        if (ok && !wr_n) begin
            if (!h_n) model[a][15:8] = d[15:8];
            if (!l_n) model[a][7:0]  = d[7:0];
        end
        sbq.push_back(e);
        if (p == 0) begin
            en_a_n = sel_n; en_a = sel; we_a_n = wr_n; hi_a_n = h_n; lo_a_n = l_n; addr_a = a; wdata_a = d;
        end else begin
            en_b_n = sel_n; en_b = sel; we_b_n = wr_n; hi_b_n = h_n; lo_b_n = l_n; addr_b = a; wdata_b = d;
        end
    endtask

    task automatic idle(input int p);
        if (p == 0) begin en_a_n = 1; en_a = 0; we_a_n = 1; hi_a_n = 1; lo_a_n = 1; end
        else        begin en_b_n = 1; en_b = 0; we_b_n = 1; hi_b_n = 1; lo_b_n = 1; end
    endtask

    task automatic wr(input int p, input logic h_n, input logic l_n, input logic [AW-1:0] a,
                      input logic [15:0] d, input string tag);
        access(p, 1'b0, 1'b1, 1'b0, h_n, l_n, a, d, tag);
    endtask

    task automatic rd(input int p, input logic h_n, input logic l_n, input logic [AW-1:0] a,
                      input string tag);
        access(p, 1'b0, 1'b1, 1'b1, h_n, l_n, a, 16'h0, tag);
    endtask

    task automatic summary_and_end();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
            summary_and_end();
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = 16'h0;
        // R10: reset state
        repeat (3) tick();
        report(rvalid_a == 2'b00 && rdata_a == 16'h0, "R10 reset quiet A", {rvalid_a, rdata_a}, 18'h0);
        report(rvalid_b == 2'b00 && rdata_b == 16'h0, "R10 reset quiet B", {rvalid_b, rdata_b}, 18'h0);
        rst_a_n = 1; rst_b_n = 1;
        tick();

        // R1 R11: full-word writes, boundary addresses, no output on write
        wr(0, 0, 0, 10'h010, 16'hA5C3, "R11 write A quiet");
        wr(1, 0, 0, 10'h020, 16'h1234, "R11 write B quiet");
        tick();
        wr(0, 0, 0, 10'h000, 16'h0F0F, "R11 write A low addr");
        wr(1, 0, 0, 10'h3FF, 16'hF00D, "R11 write B high addr");
        tick();
        // R8: both ports read the same word in the same cycle
        rd(0, 0, 0, 10'h010, "R8 R1 same word read A");
        rd(1, 0, 0, 10'h010, "R8 R7 same word read B");
        tick();
        rd(0, 0, 0, 10'h000, "R1 read lowest address");
        rd(1, 0, 0, 10'h020, "R7 pipelined read B");
        tick();
        rd(0, 0, 0, 10'h3FF, "R1 read highest address");
        idle(1);
        tick();

        // R2: single-lane writes keep the other lane
        wr(0, 0, 1, 10'h020, 16'hBEEF, "R11 upper write quiet");
        wr(1, 1, 0, 10'h010, 16'hEE77, "R11 lower write quiet");
        tick();
        rd(0, 0, 0, 10'h020, "R2 upper-only write kept lower");
        rd(1, 0, 0, 10'h010, "R2 lower-only write kept upper");
        tick();

        // R3: single-lane reads
        rd(0, 0, 1, 10'h010, "R3 upper-only read");
        rd(1, 1, 0, 10'h020, "R3 lower-only read");
        tick();

        // R4: deselected by either enable; R5: no lanes selected
        access(0, 1'b1, 1'b1, 1'b0, 0, 0, 10'h010, 16'h0000, "R4 write with en_n high");
        access(1, 1'b0, 1'b0, 1'b0, 0, 0, 10'h020, 16'h0000, "R4 write with en low");
        tick();
        access(0, 1'b1, 1'b0, 1'b1, 0, 0, 10'h010, 16'h0, "R4 read while deselected");
        wr(1, 1, 1, 10'h010, 16'h0000, "R5 write with no lanes");
        tick();
        rd(0, 1, 1, 10'h010, "R5 read with no lanes");
        idle(1);
        tick();
        rd(0, 0, 0, 10'h010, "R4 R5 word unchanged after blocked writes");
        rd(1, 0, 0, 10'h020, "R4 word unchanged after deselected write");
        tick();

        // R9: read on B and write on A to the same word at one edge
        wr(0, 0, 0, 10'h030, 16'h1111, "R11 setup write");
        idle(1);
        tick();
        rd(1, 0, 0, 10'h030, "R9 read returns old data");
        wr(0, 0, 0, 10'h030, 16'h2222, "R11 colliding write quiet");
        tick();
        rd(0, 0, 0, 10'h030, "R9 new data after collision");
        idle(1);
        tick();
        idle(0);

        // R6: asynchronous output enable inside the valid cycle
        rd(0, 0, 0, 10'h030, "R6 read before oe toggle");
        tick();
        idle(0);
        oe_a_n = 1; #1;
        report(rvalid_a == 2'b00 && rdata_a == 16'h0, "R6 oe high silences lanes", {rvalid_a, rdata_a}, 18'h0);
        oe_a_n = 0; #1;
        report(rvalid_a == 2'b11 && rdata_a == 16'h2222, "R6 lanes return with oe low",
               {rvalid_a, rdata_a}, {2'b11, 16'h2222});
        tick();

        // R10: reset while a read is requested
        rd(0, 0, 0, 10'h030, "R10 reset blocks read");
        sbq[sbq.size() - 1].lanes = 2'b00;
        rst_a_n = 0;
        tick();
        idle(0);
        rst_a_n = 1;
        tick();

        // R1 R7: pattern sweep, B writes and A/B read back
        for (int i = 0; i < 8; i++) begin
            wr(1, 0, 0, 10'h100 + 10'(i), 16'(i * 16'h1111) ^ 16'h5A5A, "R11 sweep write");
            tick();
        end
        for (int i = 0; i < 8; i++) begin
            rd(0, 0, 0, 10'h100 + 10'(i), "R1 sweep read A");
            rd(1, 0, 0, 10'h107 - 10'(i), "R7 sweep read B");
            tick();
        end
        idle(0); idle(1);
        repeat (4) tick();
        report(sbq.size() == 0, "R7 scoreboard drained", 18'(sbq.size()), 18'h0);
        summary_and_end();
    end

endmodule